// File: doc/BRIEF.md
# Accumulator and Extend-Bit Unit

This block holds the working accumulator of a small single-accumulator processor, the one-bit extend flag that catches the carry and the bit rotated out, and the combinational adder and logic stage that computes the next accumulator value. The sequencer gives it already-decoded enables: three memory-operand enables, the register-reference enable, the I/O enable, and the twelve low bits of the instruction word. It also gives it a memory operand and an 8-bit input character. The block then updates the accumulator and the extend flag on the next clock edge.

The accumulator value is always presented on an output so that a store can place it on the shared bus. A single skip flag tells the program-counter logic that the present register-reference instruction wants to skip the next instruction. Sequencing, memory and the program counter itself lie outside this block.

Top module: `accum_core`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the accumulator reads 0, the extend flag reads 0 and the skip flag reads 0.
- R2: When `mem_and_en` is high, the accumulator becomes the bitwise AND of itself and `dr_in` at the next edge, and the extend flag is unchanged.
- R3: When `mem_add_en` is high, the accumulator becomes the low 16 bits of accumulator plus `dr_in` at the next edge, and the extend flag takes the carry out of bit 15.
- R4: When `mem_ld_en` is high, the accumulator becomes `dr_in` at the next edge.
- R5: When `io_en` is high with `ir_bits[11]` set, accumulator bits 7..0 take `char_in` and bits 15..8 keep their value.
- R6: With `rr_en` high, `ir_bits[11]` clears the accumulator, `ir_bits[9]` inverts it, and `ir_bits[5]` adds 1 to it modulo 2^16, leaving the extend flag unchanged.
- R7: With `rr_en` high, `ir_bits[10]` clears the extend flag and `ir_bits[8]` inverts it, unless the selected accumulator operation itself writes the extend flag. Clear takes precedence over invert.
- R8: With `rr_en` high, `ir_bits[7]` rotates right through the extend flag (new bit 15 is the old flag, new flag is old bit 0). `ir_bits[6]` rotates left (new bit 0 is the old flag, new flag is old bit 15).
- R9: `skip_out` is high in the same cycle as the stimulus when `rr_en` is high and one of these holds: `ir_bits[4]` with accumulator bit 15 at 0, `ir_bits[3]` with bit 15 at 1, `ir_bits[2]` with the accumulator all zero, or `ir_bits[1]` with the extend flag at 0. It is never high without `rr_en`.
- R10: Instruction bits have no effect on the accumulator, the extend flag or the skip flag when neither `rr_en` nor `io_en` is asserted. With no enable at all, both registers hold.
- R11: At most one accumulator operation takes effect per clock. When several are requested, the winner follows this order: AND, add, load, character input, clear, invert, rotate right, rotate left, increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_and_en | input | 1 | Execute AND with memory operand |
| mem_add_en | input | 1 | Execute add with memory operand |
| mem_ld_en | input | 1 | Execute load of memory operand |
| rr_en | input | 1 | Register-reference instruction active |
| io_en | input | 1 | I/O instruction active |
| ir_bits | input | 12 | Low instruction bits selecting the operation |
| dr_in | input | 16 | Memory operand |
| char_in | input | 8 | Input character |
| acc_out | output | 16 | Accumulator value, drives the bus for stores |
| ext_out | output | 1 | Extend flag |
| skip_out | output | 1 | Skip-next-instruction request |

## Verification
Accumulator and extend-flag results are due one clock edge after the enables are presented, because both are single registers fed by combinational next-state logic. The bench therefore drives a stimulus between edges and compares `acc_out` and `ext_out` 1 ns after the following rising edge. The skip flag is purely combinational on the present register state, so it is compared in the same cycle as its stimulus, before any edge, and a further check confirms that the skip request itself changed no state. Each operand is rebuilt with a load and an extend-flag set before every operation, so every expected value depends only on the one operation under test.

// File: rtl/acc_pkg.sv
package acc_pkg;
  // priority order of accumulator operations: lower index wins
  localparam int IDX_AND = 0;
  localparam int IDX_ADD = 1;
  localparam int IDX_LD  = 2;
  localparam int IDX_INP = 3;
  localparam int IDX_CLR = 4;
  localparam int IDX_CPL = 5;
  localparam int IDX_ROR = 6;
  localparam int IDX_ROL = 7;
  localparam int IDX_INC = 8;
  localparam int N_OPS   = 9;

  // instruction bit positions (decoded by the sequencer's neighbours)
  localparam int CTL_W   = 12;
  localparam int B_CLRA  = 11;
  localparam int B_CLRE  = 10;
  localparam int B_CPLA  = 9;
  localparam int B_CPLE  = 8;
  localparam int B_ROR   = 7;
  localparam int B_ROL   = 6;
  localparam int B_INC   = 5;
  localparam int B_SPOS  = 4;
  localparam int B_SNEG  = 3;
  localparam int B_SZA   = 2;
  localparam int B_SZE   = 1;
  localparam int B_INP   = 11;

  typedef enum logic [2:0] {
    E_HOLD,
    E_CARRY,
    E_FROM_LSB,
    E_FROM_MSB,
    E_CLR,
    E_CPL
  } e_sel_e;
endpackage

// File: rtl/acc_op_select.sv
module acc_op_select
  import acc_pkg::*;
(
  input  logic             mem_and_en,
  input  logic             mem_add_en,
  input  logic             mem_ld_en,
  input  logic             rr_en,
  input  logic             io_en,
  input  logic [CTL_W-1:0] ir_bits,
  output logic [N_OPS-1:0] grant,
  output e_sel_e           e_sel
);
  logic [N_OPS-1:0] req;
  logic             taken;

  always_comb begin
    req          = '0;
    req[IDX_AND] = mem_and_en;
    req[IDX_ADD] = mem_add_en;
    req[IDX_LD]  = mem_ld_en;
    req[IDX_INP] = io_en & ir_bits[B_INP];
    req[IDX_CLR] = rr_en & ir_bits[B_CLRA];
    req[IDX_CPL] = rr_en & ir_bits[B_CPLA];
    req[IDX_ROR] = rr_en & ir_bits[B_ROR];
    req[IDX_ROL] = rr_en & ir_bits[B_ROL];
    req[IDX_INC] = rr_en & ir_bits[B_INC];
  end

  // fixed-priority grant: first request in index order wins
  always_comb begin
    taken = 1'b0;
    grant = '0;
    for (int k = 0; k < N_OPS; k++) begin
      grant[k] = req[k] & ~taken;
      taken    = taken | req[k];
    end
  end

  // extend-flag source: the winning AC op owns E when it writes it
  always_comb begin
    if (grant[IDX_ADD])                   e_sel = E_CARRY;
    else if (grant[IDX_ROR])              e_sel = E_FROM_LSB;
    else if (grant[IDX_ROL])              e_sel = E_FROM_MSB;
    else if (rr_en && ir_bits[B_CLRE])    e_sel = E_CLR;
    else if (rr_en && ir_bits[B_CPLE])    e_sel = E_CPL;
    else                                  e_sel = E_HOLD;
  end
endmodule

// File: rtl/acc_next.sv
module acc_next
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic [DATA_W-1:0] acc,
  input  logic              ext,
  input  logic [N_OPS-1:0]  grant,
  input  e_sel_e            e_sel,
  input  logic [DATA_W-1:0] dr,
  input  logic [CHAR_W-1:0] chr,
  output logic [DATA_W-1:0] acc_nxt,
  output logic              ext_nxt
);
  function automatic logic [DATA_W:0] add_wc(input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [DATA_W-1:0] rot_r(input logic [DATA_W-1:0] a, input logic fill);
    return {fill, a[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W-1:0] rot_l(input logic [DATA_W-1:0] a, input logic fill);
    return {a[DATA_W-2:0], fill};
  endfunction

  logic [DATA_W:0] sum_wc;
  assign sum_wc = add_wc(acc, dr);

  always_comb begin
    if (grant[IDX_AND])      acc_nxt = acc & dr;
    else if (grant[IDX_ADD]) acc_nxt = sum_wc[DATA_W-1:0];
    else if (grant[IDX_LD])  acc_nxt = dr;
    else if (grant[IDX_INP]) acc_nxt = {acc[DATA_W-1:CHAR_W], chr};
    else if (grant[IDX_CLR]) acc_nxt = '0;
    else if (grant[IDX_CPL]) acc_nxt = ~acc;
    else if (grant[IDX_ROR]) acc_nxt = rot_r(acc, ext);
    else if (grant[IDX_ROL]) acc_nxt = rot_l(acc, ext);
    else if (grant[IDX_INC]) acc_nxt = acc + DATA_W'(1);
    else                     acc_nxt = acc;
  end

  always_comb begin
    unique case (e_sel)
      E_CARRY:    ext_nxt = sum_wc[DATA_W];
      E_FROM_LSB: ext_nxt = acc[0];
      E_FROM_MSB: ext_nxt = acc[DATA_W-1];
      E_CLR:      ext_nxt = 1'b0;
      E_CPL:      ext_nxt = ~ext;
      default:    ext_nxt = ext;
    endcase
  end
endmodule

// File: rtl/acc_skip.sv
module acc_skip
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              rr_en,
  input  logic [CTL_W-1:0]  ir_bits,
  input  logic [DATA_W-1:0] acc,
  input  logic              ext,
  output logic              skip
);
  function automatic logic all_zero(input logic [DATA_W-1:0] a);
    return (a == '0);
  endfunction

  logic hit_pos, hit_neg, hit_zero, hit_ez;
  assign hit_pos  = ir_bits[B_SPOS] & ~acc[DATA_W-1];
  assign hit_neg  = ir_bits[B_SNEG] &  acc[DATA_W-1];
  assign hit_zero = ir_bits[B_SZA]  &  all_zero(acc);
  assign hit_ez   = ir_bits[B_SZE]  & ~ext;
  assign skip     = rr_en & (hit_pos | hit_neg | hit_zero | hit_ez);
endmodule

// File: rtl/accum_core.sv
module accum_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_and_en,
  input  logic              mem_add_en,
  input  logic              mem_ld_en,
  input  logic              rr_en,
  input  logic              io_en,
  input  logic [CTL_W-1:0]  ir_bits,
  input  logic [DATA_W-1:0] dr_in,
  input  logic [CHAR_W-1:0] char_in,
  output logic [DATA_W-1:0] acc_out,
  output logic              ext_out,
  output logic              skip_out
);
  logic [N_OPS-1:0]  grant;
  e_sel_e            e_sel;
  logic [DATA_W-1:0] acc_q, acc_nxt;
  logic              e_q, e_nxt;

  acc_op_select u_sel (
    .mem_and_en (mem_and_en),
    .mem_add_en (mem_add_en),
    .mem_ld_en  (mem_ld_en),
    .rr_en      (rr_en),
    .io_en      (io_en),
    .ir_bits    (ir_bits),
    .grant      (grant),
    .e_sel      (e_sel)
  );

  acc_next #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_next (
    .acc     (acc_q),
    .ext     (e_q),
    .grant   (grant),
    .e_sel   (e_sel),
    .dr      (dr_in),
    .chr     (char_in),
    .acc_nxt (acc_nxt),
    .ext_nxt (e_nxt)
  );

  acc_skip #(.DATA_W(DATA_W)) u_skip (
    .rr_en   (rr_en),
    .ir_bits (ir_bits),
    .acc     (acc_q),
    .ext     (e_q),
    .skip    (skip_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      e_q   <= 1'b0;
    end else begin
      acc_q <= acc_nxt;
      e_q   <= e_nxt;
    end
  end

  assign acc_out = acc_q;
  assign ext_out = e_q;

  AST_LOAD_TAKES_DR: assert property (@(posedge clk) disable iff (!rst_n)
    grant[IDX_LD] |=> acc_q == $past(dr_in)); // R4
  AST_INP_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    grant[IDX_INP] |=> acc_q[DATA_W-1:CHAR_W] == $past(acc_q[DATA_W-1:CHAR_W])); // R5
  AST_CLEAR_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    grant[IDX_CLR] |=> acc_q == '0); // R6
  AST_E_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    e_sel == E_HOLD |=> $stable(e_q)); // R7
  AST_SKIP_NEEDS_RR: assert property (@(posedge clk) disable iff (!rst_n)
    skip_out |-> rr_en); // R9
  AST_IDLE_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    grant == '0 |=> $stable(acc_q)); // R10
endmodule

// File: tb/accum_core_test.sv
`timescale 1ns/1ps
module accum_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_and_en = 0, mem_add_en = 0, mem_ld_en = 0, rr_en = 0, io_en = 0;
  logic [11:0] ir_bits = '0;
  logic [15:0] dr_in = '0;
  logic [7:0]  char_in = '0;
  logic [15:0] acc_out;
  logic        ext_out, skip_out;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  accum_core uut (
    .clk(clk), .rst_n(rst_n), .mem_and_en(mem_and_en), .mem_add_en(mem_add_en),
    .mem_ld_en(mem_ld_en), .rr_en(rr_en), .io_en(io_en), .ir_bits(ir_bits),
    .dr_in(dr_in), .char_in(char_in), .acc_out(acc_out), .ext_out(ext_out),
    .skip_out(skip_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    mem_and_en = 0; mem_add_en = 0; mem_ld_en = 0; rr_en = 0; io_en = 0;
    ir_bits = '0; dr_in = '0; char_in = '0;
  endtask

  // present a stimulus mid-cycle, let one edge pass, sample 1 ns later
  task automatic run(input logic a_en, input logic ad_en, input logic ld_en,
                     input logic rr, input logic io, input logic [11:0] bits,
                     input logic [15:0] dr, input logic [7:0] ch);
    mem_and_en = a_en; mem_add_en = ad_en; mem_ld_en = ld_en;
    rr_en = rr; io_en = io; ir_bits = bits; dr_in = dr; char_in = ch;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic ld(input int v);
    run(0, 0, 1, 0, 0, 12'h000, 16'(v), 8'h00);
  endtask

  task automatic set_e(input int v);
    run(0, 0, 0, 1, 0, 12'h400, 16'h0, 8'h00);
    if (v != 0) run(0, 0, 0, 1, 0, 12'h100, 16'h0, 8'h00);
  endtask

  task automatic skip_probe(input string tag, input logic [11:0] bits, input int exp);
    rr_en = 1; ir_bits = bits;
    #2;
    chk(tag, int'(skip_out), exp);
    @(posedge clk); #1;
    idle();
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 acc in reset", int'(acc_out), 0);
    chk("R1 ext in reset", int'(ext_out), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 acc after reset", int'(acc_out), 0);
    chk("R1 ext after reset", int'(ext_out), 0);
    chk("R1 skip after reset", int'(skip_out), 0);

    for (int i = 0; i < 64; i++) begin
      int a, b, e0, s, ch;
      a  = (i * 40503 + 4660) % 65536;
      b  = (i * 9973 + 21845) % 65536;
      if (i == 62) a = 32768;
      if (i == 63) a = 0;
      if (i == 61) begin a = 65535; b = 1; end
      e0 = i % 2;
      ch = (i * 37 + 1) % 256;

      ld(a);
      chk("R4 load", int'(acc_out), a);
      set_e(e0);
      chk("R7 set ext", int'(ext_out), e0);
      chk("R4 ext kept by load", int'(acc_out), a);

      skip_probe("R9 skip positive", 12'h010, (a < 32768) ? 1 : 0);
      skip_probe("R9 skip negative", 12'h008, (a >= 32768) ? 1 : 0);
      skip_probe("R9 skip acc zero", 12'h004, (a == 0) ? 1 : 0);
      skip_probe("R9 skip ext zero", 12'h002, (e0 == 0) ? 1 : 0);
      chk("R9 skip leaves acc", int'(acc_out), a);

      run(1, 0, 0, 0, 0, 12'h000, 16'(b), 8'h00);
      chk("R2 and", int'(acc_out), a & b);
      chk("R2 ext kept", int'(ext_out), e0);

      ld(a);
      run(0, 1, 0, 0, 0, 12'h000, 16'(b), 8'h00);
      s = a + b;
      chk("R3 add sum", int'(acc_out), s % 65536);
      chk("R3 add carry", int'(ext_out), s / 65536);

      ld(a); set_e(e0);
      run(0, 0, 0, 1, 0, 12'h080, 16'h0, 8'h00);
      chk("R8 rotate right acc", int'(acc_out), a / 2 + e0 * 32768);
      chk("R8 rotate right ext", int'(ext_out), a % 2);

      ld(a); set_e(e0);
      run(0, 0, 0, 1, 0, 12'h040, 16'h0, 8'h00);
      chk("R8 rotate left acc", int'(acc_out), (a * 2) % 65536 + e0);
      chk("R8 rotate left ext", int'(ext_out), a / 32768);

      ld(a); set_e(e0);
      run(0, 0, 0, 1, 0, 12'h200, 16'h0, 8'h00);
      chk("R6 complement", int'(acc_out), 65535 - a);
      ld(a);
      run(0, 0, 0, 1, 0, 12'h020, 16'h0, 8'h00);
      chk("R6 increment", int'(acc_out), (a + 1) % 65536);
      chk("R6 increment ext kept", int'(ext_out), e0);
      ld(a);
      run(0, 0, 0, 1, 0, 12'h800, 16'h0, 8'h00);
      chk("R6 clear", int'(acc_out), 0);

      ld(a);
      run(0, 0, 0, 0, 1, 12'h800, 16'h0, 8'(ch));
      chk("R5 char input", int'(acc_out), (a / 256) * 256 + ch);
      chk("R5 ext kept", int'(ext_out), e0);

      // complement E twice from a known value
      set_e(e0);
      run(0, 0, 0, 1, 0, 12'h100, 16'h0, 8'h00);
      chk("R7 complement ext", int'(ext_out), 1 - e0);
    end

    // R10: bits with no enable do nothing
    ld(16'h8001); set_e(1);
    rr_en = 0; io_en = 0; ir_bits = 12'hFFF;
    #2;
    chk("R10 skip without rr", int'(skip_out), 0);
    @(posedge clk); #1;
    idle();
    chk("R10 acc unchanged", int'(acc_out), 16'h8001);
    chk("R10 ext unchanged", int'(ext_out), 1);
    run(0, 0, 0, 0, 0, 12'h000, 16'h1234, 8'h55);
    chk("R10 idle holds acc", int'(acc_out), 16'h8001);

    // R11 priorities
    ld(16'h0F0F); set_e(1);
    run(1, 1, 0, 0, 0, 12'h000, 16'h00FF, 8'h00);
    chk("R11 and beats add", int'(acc_out), 16'h000F);
    chk("R11 ext kept when and wins", int'(ext_out), 1);
    ld(16'h1234);
    run(0, 0, 1, 1, 0, 12'h800, 16'hBEEF, 8'h00);
    chk("R11 load beats clear", int'(acc_out), 16'hBEEF);
    ld(16'h1234);
    run(0, 0, 0, 1, 0, 12'hA00, 16'h0, 8'h00);
    chk("R11 clear beats complement", int'(acc_out), 0);
    ld(16'h1234); set_e(0);
    run(0, 0, 0, 1, 0, 12'h280, 16'h0, 8'h00);
    chk("R11 complement beats rotate", int'(acc_out), 16'hEDCB);
    chk("R11 ext kept by complement", int'(ext_out), 0);
    ld(16'h0003); set_e(0);
    run(0, 0, 0, 1, 0, 12'h0E0, 16'h0, 8'h00);
    chk("R11 rotate right beats left and inc", int'(acc_out), 16'h0001);
    chk("R11 ext from rotate right", int'(ext_out), 1);
    ld(16'h8000); set_e(1);
    run(0, 0, 0, 1, 0, 12'h440, 16'h0, 8'h00);
    chk("R7 rotate owns ext over clear", int'(ext_out), 1);
    chk("R8 rotate left with clear req", int'(acc_out), 16'h0001);
    ld(16'h5555); set_e(1);
    run(0, 0, 0, 1, 0, 12'hD00, 16'h0, 8'h00);
    chk("R7 clear ext beats complement", int'(ext_out), 0);
    chk("R6 clear acc alongside ext ops", int'(acc_out), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule